// File: doc/BRIEF.md
# UART Fractional Baud and Frame Generator

This block sets the timing and frame shape for a serial transmitter and receiver that are built elsewhere. Software-side logic writes three settings through a plain valid/address/data port: a line-control word, a 16-bit integer divisor and a 3-bit fractional divisor. From a fixed reference clock, which is nominally 24 MHz, the block produces a 16x oversample tick and a one-cycle strobe that marks the end of each bit period. It also reports the decoded frame shape: the data width, the stop-bit count, the parity mode and the total number of bits in a frame.

A bit period lasts 16 times (integer divisor + 1) reference cycles, plus as many extra cycles as the fractional field gives. The extra cycles are spread one each over the first ticks of the bit, so no two tick spacings differ by more than one cycle. Writes go into shadow registers. The running settings are reloaded only at a bit boundary, on a restart, or when the generator starts from idle. A zero integer divisor stops the generator and freezes the running settings.

Top module: `uart_baud_frame_gen`

## Requirements
- R1: The data width output equals line-control bits [1:0] plus 5, giving 5 to 8.
- R2: Line-control bit 2 set selects two stop bits, and clear selects one. The stop output is 1 when two stop bits are selected.
- R3: Line-control bit 5 enables parity, and bit 3 then chooses even (set) or odd (clear). The parity mode output is 0 for none, 1 for odd and 2 for even. Bit 3 has no effect while bit 5 is clear.
- R4: The frame length output equals 1 start bit, plus the data bits, plus 1 when parity is enabled, plus the stop bits. It always lies in 7..12.
- R5: Consecutive bit strobes are 16*(D+1)+F reference cycles apart, where D is the integer divisor and F is the fractional value. Each bit holds exactly 16 oversample ticks, and the strobe coincides with the 16th tick.
- R6: Within a bit, the first F ticks are spaced D+2 cycles apart and the remaining ticks D+1 cycles apart.
- R7: While the written integer divisor is zero, no tick or strobe occurs and the frame outputs keep their values, even when the line-control word is written.
- R8: Register addresses are 0 for line control, 1 for the integer divisor and 2 for the fractional divisor. Writes to address 3 are ignored. A write while running changes the frame outputs and the timing only from the bit that follows the next strobe.
- R9: A one-cycle restart input starts a new bit using the latest written settings. The next strobe follows 16*(D+1)+F cycles after the restart edge.
- R10: After reset there are no ticks. The frame outputs show 5 data bits, one stop bit, no parity and a length of 7.
- R11: Writing a nonzero integer divisor while idle starts a new bit two clock edges after the write is presented. The first strobe arrives one full bit period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrValid | input | 1 | Register write request |
| wrAddr | input | 2 | Register select for the write |
| wrData | input | 16 | Write data; the low bits are used for narrower registers |
| restart | input | 1 | Synchronous restart to the start of a bit |
| ovsTick | output | 1 | 16x oversample tick, one cycle wide |
| bitStrobe | output | 1 | End-of-bit strobe, one cycle wide |
| dataBits | output | 4 | Data bits per frame (5..8) |
| stopTwo | output | 1 | 1 when two stop bits are selected |
| parityMode | output | 2 | 0 none, 1 odd, 2 even |
| frameBits | output | 4 | Total bits per frame |

## Verification
A table of seven settings sweeps every data width, both stop counts and all three parity modes. It includes a word with the even-select bit set but parity off, which tells whether the parity enable is honoured. The divisors are paired with fractional values of 0, 1, 3, 5 and 7, so the measured bit length separates the integer and fractional terms. The count of long tick spacings shows whether the extra cycles go to the first ticks of the bit. Directed cases then cover the exact start latency from idle, the restart latency, the deferral of a write mid-bit to the next boundary, the ignored address, and freezing under a zero divisor.

// File: rtl/baud_frame_pkg.sv
package baud_frame_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_ODD  = 2'd1,
    PAR_EVEN = 2'd2
  } parMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic run;    // counters may advance
    logic clear;  // return counters to the start of a bit
    logic load;   // copy shadow settings into the running set
  } baudCtl_t;

  localparam logic [1:0] ADDR_LINE = 2'd0;
  localparam logic [1:0] ADDR_IDIV = 2'd1;
  localparam logic [1:0] ADDR_FDIV = 2'd2;

  // line-control field positions
  localparam int LC_LEN_LO  = 0;
  localparam int LC_STOP    = 2;
  localparam int LC_EVEN    = 3;
  localparam int LC_PAR_EN  = 5;
  localparam int MIN_DATA   = 5;

endpackage

// File: rtl/baud_frame_decode.sv
module baud_frame_decode
  import baud_frame_pkg::*;
#(
  parameter int LCR_W = 8
) (
  input  logic [LCR_W-1:0] lineWord,
  output logic [3:0]       dataBits,
  output logic             stopTwo,
  output parMode_e         parityMode,
  output logic [3:0]       frameBits
);

  logic [1:0] lenField;
  logic       parOn;

  assign lenField = lineWord[LC_LEN_LO +: 2];
  assign parOn    = lineWord[LC_PAR_EN];
  assign stopTwo  = lineWord[LC_STOP];

  always_comb begin
    dataBits = 4'(lenField) + 4'(MIN_DATA);
    if (!parOn)                parityMode = PAR_NONE;
    else if (lineWord[LC_EVEN]) parityMode = PAR_EVEN;
    else                       parityMode = PAR_ODD;
    frameBits = 4'd1 + dataBits + (parOn ? 4'd1 : 4'd0) + (stopTwo ? 4'd2 : 4'd1);
  end

endmodule

// File: rtl/baud_frame_ctrl.sv
module baud_frame_ctrl
  import baud_frame_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 3,
  parameter int LCR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [1:0]        wrAddr,
  input  logic [DIV_W-1:0]  wrData,
  input  logic              restart,
  input  logic              bitEnd,
  output baudCtl_t          ctl,
  output logic [LCR_W-1:0]  shLine,
  output logic [DIV_W-1:0]  shDiv,
  output logic [FRAC_W-1:0] shFrac,
  output logic              shadowZero
);

  logic running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shLine <= '0;
      shDiv  <= '0;
      shFrac <= '0;
    end else if (wrValid) begin
      unique case (wrAddr)
        ADDR_LINE: shLine <= wrData[LCR_W-1:0];
        ADDR_IDIV: shDiv  <= wrData;
        ADDR_FDIV: shFrac <= wrData[FRAC_W-1:0];
        default: ;
      endcase
    end
  end

  assign shadowZero = (shDiv == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) running <= 1'b0;
    else       running <= !shadowZero;
  end

  always_comb begin
    ctl.run   = running && !shadowZero;
    ctl.clear = shadowZero || !running || restart;
    ctl.load  = !shadowZero && (!running || restart || bitEnd);
  end

endmodule

// File: rtl/baud_frame_datapath.sv
module baud_frame_datapath
  import baud_frame_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 3,
  parameter int LCR_W  = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  baudCtl_t          ctl,
  input  logic [LCR_W-1:0]  shLine,
  input  logic [DIV_W-1:0]  shDiv,
  input  logic [FRAC_W-1:0] shFrac,
  output logic              ovsTick,
  output logic              bitStrobe,
  output logic [LCR_W-1:0]  actLine
);

  localparam int CNT_W = DIV_W + 1;
  localparam int SUB_W = $clog2(OVS);
  localparam int CMP_W = (SUB_W > FRAC_W) ? SUB_W : FRAC_W;
  localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(OVS - 1);

  logic [DIV_W-1:0]  actDiv;
  logic [FRAC_W-1:0] actFrac;
  logic [CNT_W-1:0]  cycCnt;
  logic [SUB_W-1:0]  subIdx;
  logic              extraCyc;
  logic [CNT_W-1:0]  tickLast;

  // running settings, refreshed only when control asks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actLine <= '0;
      actDiv  <= '0;
      actFrac <= '0;
    end else if (ctl.load) begin
      actLine <= shLine;
      actDiv  <= shDiv;
      actFrac <= shFrac;
    end
  end

  // first actFrac ticks of each bit get one extra reference cycle
  generate
    if (FRAC_W > 0) begin : g_spread
      assign extraCyc = (CMP_W'(subIdx) < CMP_W'(actFrac));
    end else begin : g_plain
      assign extraCyc = 1'b0;
    end
  endgenerate

  assign tickLast  = {1'b0, actDiv} + CNT_W'(extraCyc);
  assign ovsTick   = ctl.run && (cycCnt == tickLast);
  assign bitStrobe = ovsTick && (subIdx == LAST_SUB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCnt <= '0;
      subIdx <= '0;
    end else if (ctl.clear) begin
      cycCnt <= '0;
      subIdx <= '0;
    end else if (ctl.run) begin
      if (ovsTick) begin
        cycCnt <= '0;
        subIdx <= bitStrobe ? '0 : subIdx + 1'b1;
      end else begin
        cycCnt <= cycCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/uart_baud_frame_gen.sv
module uart_baud_frame_gen
  import baud_frame_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 3,
  parameter int LCR_W  = 8,
  parameter int OVS    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic [1:0]       wrAddr,
  input  logic [DIV_W-1:0] wrData,
  input  logic             restart,
  output logic             ovsTick,
  output logic             bitStrobe,
  output logic [3:0]       dataBits,
  output logic             stopTwo,
  output logic [1:0]       parityMode,
  output logic [3:0]       frameBits
);

  baudCtl_t          ctl;
  logic [LCR_W-1:0]  shLine;
  logic [DIV_W-1:0]  shDiv;
  logic [FRAC_W-1:0] shFrac;
  logic              shadowZero;
  logic [LCR_W-1:0]  actLine;
  logic              loadNow;
  parMode_e          parEnum;

  baud_frame_ctrl #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .LCR_W(LCR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .restart(restart), .bitEnd(bitStrobe), .ctl(ctl), .shLine(shLine),
    .shDiv(shDiv), .shFrac(shFrac), .shadowZero(shadowZero)
  );

  baud_frame_datapath #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .LCR_W(LCR_W), .OVS(OVS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .shLine(shLine), .shDiv(shDiv),
    .shFrac(shFrac), .ovsTick(ovsTick), .bitStrobe(bitStrobe), .actLine(actLine)
  );

  baud_frame_decode #(.LCR_W(LCR_W)) u_dec (
    .lineWord(actLine), .dataBits(dataBits), .stopTwo(stopTwo),
    .parityMode(parEnum), .frameBits(frameBits)
  );

  assign parityMode = parEnum;
  assign loadNow    = ctl.load;

endmodule

// File: rtl/baud_frame_checker.sv
module baud_frame_checker (
  input logic       clk,
  input logic       rstN,
  input logic       ovsTick,
  input logic       bitStrobe,
  input logic [3:0] frameBits,
  input logic       loadNow,
  input logic       shadowZero
);

  logic [4:0] tickCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    tickCnt <= '0;
    else if (bitStrobe || loadNow) tickCnt <= '0;
    else if (ovsTick)              tickCnt <= tickCnt + 1'b1;
  end

  AST_STROBE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |-> ovsTick); // R5

  AST_SIXTEEN_TICKS: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |-> (tickCnt == 5'd15)); // R5

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    shadowZero |-> !ovsTick); // R7

  AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (frameBits >= 4'd7) && (frameBits <= 4'd12)); // R4

  AST_HOLD_UNTIL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !loadNow |=> $stable(frameBits)); // R8

endmodule

bind uart_baud_frame_gen baud_frame_checker u_chk (
  .clk(clk), .rstN(rstN), .ovsTick(ovsTick), .bitStrobe(bitStrobe),
  .frameBits(frameBits), .loadNow(loadNow), .shadowZero(shadowZero)
);

// File: tb/uart_baud_frame_gen_test.sv
module uart_baud_frame_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 5000;

  typedef struct packed {
    logic [7:0]  lcr;
    logic [15:0] div;
    logic [2:0]  frac;
    logic [3:0]  frame;
    logic [3:0]  data;
    logic        stop;
    logic [1:0]  par;
    logic [19:0] period;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 16'd1, 3'd0, 4'd7,  4'd5, 1'b0, 2'd0, 20'd32},
    '{8'h03, 16'd2, 3'd3, 4'd10, 4'd8, 1'b0, 2'd0, 20'd51},
    '{8'h07, 16'd1, 3'd7, 4'd11, 4'd8, 1'b1, 2'd0, 20'd39},
    '{8'h2B, 16'd3, 3'd1, 4'd11, 4'd8, 1'b0, 2'd2, 20'd65},
    '{8'h26, 16'd4, 3'd5, 4'd11, 4'd7, 1'b1, 2'd1, 20'd85},
    '{8'h01, 16'd1, 3'd1, 4'd8,  4'd6, 1'b0, 2'd0, 20'd33},
    '{8'h0A, 16'd2, 3'd0, 4'd9,  4'd7, 1'b0, 2'd0, 20'd48}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        restart = 1'b0;
  logic        ovsTick, bitStrobe, stopTwo;
  logic [3:0]  dataBits, frameBits;
  logic [1:0]  parityMode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  uart_baud_frame_gen uut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .restart(restart), .ovsTick(ovsTick), .bitStrobe(bitStrobe),
    .dataBits(dataBits), .stopTwo(stopTwo), .parityMode(parityMode),
    .frameBits(frameBits)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic waitStrobe();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!bitStrobe && n < LIMIT);
  endtask

  // called at the negedge showing a strobe; runs to the next strobe
  task automatic measureBit(input int div, output int period, output int ticks,
                            output int longCnt, output int badSp);
    int n = 0;
    int last = 0;
    ticks = 0; longCnt = 0; badSp = 0;
    do begin
      @(negedge clk);
      n++;
      if (ovsTick) begin
        if (n - last == div + 2) longCnt++;
        else if (n - last != div + 1) badSp++;
        last = n;
        ticks++;
      end
    end while (!bitStrobe && n < LIMIT);
    period = n;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int period, ticks, longCnt, badSp, seen, c;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10: reset state, silent generator
    seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (ovsTick || bitStrobe) seen++;
    end
    check("R10 ticks after reset", seen, 0);
    check("R10 frame length", frameBits, 7);
    check("R10 data width", dataBits, 5);
    check("R10 stop", stopTwo, 0);
    check("R10 parity", parityMode, 0);

    // R11: start from idle with exact latency
    writeReg(2'd0, 16'h0003);
    writeReg(2'd2, 16'd0);
    writeReg(2'd1, 16'd1);
    c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (!bitStrobe && c < LIMIT);
    check("R11 first strobe latency", c, 32);
    check("R11 frame after start", frameBits, 10);

    // table walk: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      writeReg(2'd0, 16'(VECS[v].lcr));
      writeReg(2'd1, VECS[v].div);
      writeReg(2'd2, 16'(VECS[v].frac));
      waitStrobe();
      measureBit(int'(VECS[v].div), period, ticks, longCnt, badSp);
      check("R5 bit period", period, int'(VECS[v].period));
      check("R5 ticks per bit", ticks, 16);
      check("R6 long tick count", longCnt, int'(VECS[v].frac));
      check("R6 odd spacing count", badSp, 0);
      check("R4 frame length", frameBits, int'(VECS[v].frame));
      check("R1 data width", dataBits, int'(VECS[v].data));
      check("R2 stop bits", stopTwo, int'(VECS[v].stop));
      check("R3 parity mode", parityMode, int'(VECS[v].par));
    end

    // R8: address 3 ignored; settings now 0x0A, div 2, frac 0
    writeReg(2'd3, 16'h0000);
    waitStrobe();
    measureBit(2, period, ticks, longCnt, badSp);
    check("R8 address 3 ignored period", period, 48);
    check("R8 address 3 ignored frame", frameBits, 9);

    // R8: mid-bit write deferred to the next boundary
    writeReg(2'd0, 16'h002B);
    waitStrobe();
    check("R8 frame before boundary", frameBits, 9);
    @(negedge clk);
    check("R8 frame after boundary", frameBits, 11);

    // R9: restart picks up new settings and restarts the bit
    writeReg(2'd1, 16'd2);
    writeReg(2'd2, 16'd3);
    repeat (5) @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    c = 1;
    while (!bitStrobe && c < LIMIT) begin
      @(negedge clk);
      c++;
    end
    check("R9 restart to strobe", c, 51);

    // R7: zero divisor freezes everything
    writeReg(2'd1, 16'd0);
    writeReg(2'd0, 16'h0000);
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (ovsTick || bitStrobe) seen++;
    end
    check("R7 ticks while zero", seen, 0);
    check("R7 frame held", frameBits, 11);
    check("R7 parity held", parityMode, 2);
    writeReg(2'd1, 16'd1);
    @(negedge clk);
    check("R7 frame after resume", frameBits, 7);
    waitStrobe();
    measureBit(1, period, ticks, longCnt, badSp);
    check("R7 period after resume", period, 35);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule